// File: doc/BRIEF.md
# Prioritized Non-Maskable Interrupt Arbiter

This block takes three asynchronous non-maskable interrupt pins, synchronizes them, and turns each rising edge into a request. A fixed priority orders the three sources, with source 2 highest and source 0 lowest. The winning request goes to the core on a request/acknowledge handshake, together with a two-bit source code. The block tracks which source is in service, and the core ends that service with a return strobe. The core also drives its NMI-disable status bit (np) into the block. Maskable interrupt enables do not affect any part of this path.

Whether a new edge preempts the current service, waits, or is lost depends on which source is in service, which source arrives, and the np bit. When source 0 is in service, a new source 0 edge waits and a source 2 edge preempts. A source 1 edge waits while np is 1 and preempts while np is 0. When source 1 or source 2 is in service, the block accepts nothing further. Each entry pulses one write strobe for the single shared save register pair that holds the return PC and PSW, so a nested entry overwrites that pair.

Top module: `nmi_arbiter`

## Requirements
- R1: A source raises a request only on a 0-to-1 change of its pin. A held high level yields one request. With SYNC_STAGES=2, req_o rises in the third clock cycle after the pin rises.
- R2: If edges of several sources arrive in the same cycle, only the highest (2 over 1 over 0) is recorded and the lower ones are discarded.
- R3: req_o stays high with req_src_o (0, 1 or 2) until ack_i is sampled high. On that edge the source's pending flag clears and svc_valid_o=1 with svc_src_o equal to the granted code. save_we_o is high exactly in the cycle where req_o and ack_i are both high.
- R4: While source 0 is in service, a new source 0 edge is held whatever np_i is, and it is requested only after ret_i.
- R5: While source 0 is in service, a source 1 edge is held while np_i=1 and is requested at once while np_i=0, including when np_i falls with the edge already held.
- R6: While source 0 is in service, a source 2 edge is requested at once whatever np_i is.
- R7: While source 1 or 2 is in service, edges on all pins are dropped, so no request appears even after ret_i.
- R8: ret_i clears the in-service state at the next clock edge, and any held request appears in the cycle after that edge. If ack_i and ret_i coincide, the entry wins.
- R9: After reset, req_o, save_we_o and svc_valid_o are 0 and nothing is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| nmi_i | input | 3 | Asynchronous NMI pins, bit n is source n |
| np_i | input | 1 | NMI-disable status bit from the core |
| ack_i | input | 1 | Core accepts the presented request |
| ret_i | input | 1 | Return-from-NMI strobe |
| req_o | output | 1 | Request to the core |
| req_src_o | output | 2 | Code of the requesting source |
| save_we_o | output | 1 | Write strobe for the saved PC/PSW pair |
| svc_valid_o | output | 1 | An NMI is in service |
| svc_src_o | output | 2 | Code of the source in service |

## Verification
The bench builds the block with the default SYNC_STAGES of 2. At that depth the pin-to-request delay is three cycles, so the bench can check that latency exactly. It can then place held, preempting and dropped edges against the in-service state at known cycles. A table covers every combination of simultaneous edges from idle. Directed tests cover nesting on source 0 with np at both values, np falling while a request is held, preemption by source 2, lockout after entry of source 1 or 2, a held-high pin, and an entry that coincides with a return.

// File: rtl/nmi_arb_pkg.sv
package nmi_arb_pkg;
  localparam int NUM_SRC = 3;
  localparam int SRC_W   = 2;

  typedef enum logic [SRC_W-1:0] {
    SRC_N0 = 2'd0,
    SRC_N1 = 2'd1,
    SRC_N2 = 2'd2
  } src_e;
endpackage

// File: rtl/nmi_edge_det.sv
module nmi_edge_det #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pin_i,
  output logic rise_o
);
  logic [STAGES-1:0] sync_q;
  logic              last_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= '0;
      last_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], pin_i};
      last_q <= sync_q[STAGES-1];
    end
  end

  assign rise_o = sync_q[STAGES-1] & ~last_q;

  // R1
  single_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rise_o |=> !rise_o);
endmodule

// File: rtl/nmi_arb_core.sv
module nmi_arb_core import nmi_arb_pkg::*; (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_SRC-1:0] rise_i,
  input  logic               np_i,
  input  logic               ack_i,
  input  logic               ret_i,
  output logic               req_o,
  output logic [SRC_W-1:0]   req_src_o,
  output logic               save_we_o,
  output logic               svc_valid_o,
  output logic [SRC_W-1:0]   svc_src_o
);
  logic [NUM_SRC-1:0] pend_q, sel_edge, new_pend, elig, clr;
  logic               svc_valid_q, lockout, take;
  src_e               svc_src_q, req_src;

  assign lockout = svc_valid_q && (svc_src_q != SRC_N0);

  // lower simultaneous edges are discarded
  always_comb begin
    if (rise_i[2])      sel_edge = 3'b100;
    else if (rise_i[1]) sel_edge = 3'b010;
    else if (rise_i[0]) sel_edge = 3'b001;
    else                sel_edge = 3'b000;
  end

  assign new_pend = lockout ? '0 : sel_edge;

  always_comb begin
    if (!svc_valid_q)              elig = pend_q;
    else if (svc_src_q == SRC_N0)  elig = {pend_q[2], pend_q[1] & ~np_i, 1'b0};
    else                           elig = '0;
  end

  always_comb begin
    if (elig[2])      req_src = SRC_N2;
    else if (elig[1]) req_src = SRC_N1;
    else              req_src = SRC_N0;
  end

  assign req_o = |elig;
  assign take  = req_o & ack_i;

  always_comb begin
    clr = '0;
    if (take) clr[req_src] = 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q      <= '0;
      svc_valid_q <= 1'b0;
      svc_src_q   <= SRC_N0;
    end else begin
      pend_q <= (pend_q & ~clr) | new_pend;
      if (take) begin
        svc_valid_q <= 1'b1;
        svc_src_q   <= req_src;
      end else if (ret_i) begin
        svc_valid_q <= 1'b0;
      end
    end
  end

  assign req_src_o   = req_src;
  assign save_we_o   = take;
  assign svc_valid_o = svc_valid_q;
  assign svc_src_o   = svc_src_q;

  // R3
  grant_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_o && ack_i) |=> (svc_valid_o && svc_src_o == $past(req_src_o)));
  // R7
  lockout_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (svc_valid_q && svc_src_q != SRC_N0) |-> !req_o);
  // R4
  n0_nest_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (svc_valid_q && svc_src_q == SRC_N0 && req_o) |-> (req_src_o != 2'd0));
  // R5
  n1_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (svc_valid_q && svc_src_q == SRC_N0 && np_i && !pend_q[2]) |-> !req_o);
  // R8
  ret_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ret_i && !(req_o && ack_i)) |=> !svc_valid_o);
endmodule

// File: rtl/nmi_arbiter.sv
module nmi_arbiter import nmi_arb_pkg::*; #(
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_SRC-1:0] nmi_i,
  input  logic               np_i,
  input  logic               ack_i,
  input  logic               ret_i,
  output logic               req_o,
  output logic [SRC_W-1:0]   req_src_o,
  output logic               save_we_o,
  output logic               svc_valid_o,
  output logic [SRC_W-1:0]   svc_src_o
);
  logic [NUM_SRC-1:0] rise;

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_pin
    nmi_edge_det #(.STAGES(SYNC_STAGES)) edge_i (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .pin_i  (nmi_i[g]),
      .rise_o (rise[g])
    );
  end

  nmi_arb_core core_i (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .rise_i      (rise),
    .np_i        (np_i),
    .ack_i       (ack_i),
    .ret_i       (ret_i),
    .req_o       (req_o),
    .req_src_o   (req_src_o),
    .save_we_o   (save_we_o),
    .svc_valid_o (svc_valid_o),
    .svc_src_o   (svc_src_o)
  );
endmodule

// File: tb/nmi_arbiter_tb_top.sv
module nmi_arbiter_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] nmi = '0;
  logic       np = 1'b0, ack = 1'b0, ret = 1'b0;
  logic       req, save_we, svc_valid;
  logic [1:0] req_src, svc_src;
  int         n_chk = 0, n_fail = 0;
  bit         done = 1'b0;

  always #4 clk = ~clk;

  nmi_arbiter dut_i (
    .clk_i(clk), .rst_ni(rst_n), .nmi_i(nmi), .np_i(np), .ack_i(ack), .ret_i(ret),
    .req_o(req), .req_src_o(req_src), .save_we_o(save_we),
    .svc_valid_o(svc_valid), .svc_src_o(svc_src)
  );

  // {pins, expected req, expected src}
  localparam logic [5:0] VEC [8] = '{
    {3'b001, 1'b1, 2'd0}, {3'b010, 1'b1, 2'd1}, {3'b100, 1'b1, 2'd2},
    {3'b011, 1'b1, 2'd1}, {3'b101, 1'b1, 2'd2}, {3'b110, 1'b1, 2'd2},
    {3'b111, 1'b1, 2'd2}, {3'b000, 1'b0, 2'd0}
  };

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic pulse(input logic [2:0] m);
    nmi = '0;
    repeat (2) @(negedge clk);
    nmi = m;
    repeat (3) @(negedge clk);
    nmi = '0;
  endtask

  task automatic do_ack();
    ack = 1'b1;
    #1 chk("R3 save_we on ack", int'(save_we), 1);
    @(negedge clk);
    ack = 1'b0;
    #1 chk("R3 save_we after ack", int'(save_we), 0);
  endtask

  task automatic do_ret();
    ret = 1'b1;
    @(negedge clk);
    ret = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++; n_chk++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R9 reset state
    chk("R9 req", int'(req), 0);
    chk("R9 save_we", int'(save_we), 0);
    chk("R9 svc_valid", int'(svc_valid), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R2 table from idle
    for (int i = 0; i < 8; i++) begin
      pulse(VEC[i][5:3]);
      chk("R2 req", int'(req), int'(VEC[i][2]));
      if (VEC[i][2]) begin
        chk("R2 src", int'(req_src), int'(VEC[i][1:0]));
        do_ack();
        chk("R3 svc_valid", int'(svc_valid), 1);
        chk("R3 svc_src", int'(svc_src), int'(VEC[i][1:0]));
        do_ret();
        chk("R8 svc cleared", int'(svc_valid), 0);
        chk("R2 lower discarded", int'(req), 0);
      end
    end

    // R1 latency and level
    repeat (2) @(negedge clk);
    nmi = 3'b001;
    repeat (2) @(negedge clk);
    chk("R1 no req at 2", int'(req), 0);
    @(negedge clk);
    chk("R1 req at 3", int'(req), 1);
    repeat (3) @(negedge clk);
    chk("R3 req held", int'(req), 1);
    do_ack();
    do_ret();
    repeat (6) @(negedge clk);
    chk("R1 level no rerequest", int'(req), 0);
    nmi = '0;

    // R4/R5 nesting on source 0 with np=1
    np = 1'b1;
    pulse(3'b001); do_ack();
    pulse(3'b001);
    chk("R4 n0 held", int'(req), 0);
    pulse(3'b010);
    chk("R5 n1 held np=1", int'(req), 0);
    do_ret();
    chk("R8 held issues", int'(req), 1);
    chk("R8 highest held", int'(req_src), 1);
    do_ack();
    chk("R3 svc n1", int'(svc_src), 1);
    do_ret();
    chk("R4 n0 after ret", int'(req), 1);
    chk("R4 n0 src", int'(req_src), 0);
    do_ack();

    // R5 np falls with n1 held
    pulse(3'b010);
    chk("R5 held", int'(req), 0);
    np = 1'b0;
    #1 chk("R5 np fall issues", int'(req), 1);
    chk("R5 src", int'(req_src), 1);
    do_ack();
    chk("R5 svc n1", int'(svc_src), 1);
    // R7 lockout under n1
    pulse(3'b100);
    chk("R7 n2 dropped in n1", int'(req), 0);
    do_ret();
    chk("R7 dropped after ret", int'(req), 0);

    // R5 np=0 immediate
    pulse(3'b001); do_ack();
    pulse(3'b010);
    chk("R5 n1 immediate np=0", int'(req), 1);
    do_ack();
    do_ret();

    // R6 n2 preempts with np=1, R7 lockout under n2
    np = 1'b1;
    pulse(3'b001); do_ack();
    pulse(3'b100);
    chk("R6 n2 preempts", int'(req), 1);
    chk("R6 src", int'(req_src), 2);
    // R8 entry wins over coincident return
    ret = 1'b1;
    do_ack();
    ret = 1'b0;
    chk("R8 ack wins", int'(svc_valid), 1);
    chk("R6 svc n2", int'(svc_src), 2);
    np = 1'b0;
    pulse(3'b011);
    chk("R7 dropped in n2", int'(req), 0);
    pulse(3'b001);
    do_ret();
    chk("R7 nothing after ret", int'(req), 0);
    chk("R8 idle", int'(svc_valid), 0);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule